// File: doc/BRIEF.md
# 12-bit Accumulator Machine Memory-Reference Core

This block is the sequencing and datapath core of a 12-bit word accumulator machine that addresses 4096 words, organised as 32 pages of 128 words. It fetches an instruction from a synchronous single-port memory, decodes it, and resolves the operand address. The 7-bit offset is placed either on page zero or on the page that holds the instruction, and one extra memory read is added when the indirect flag is set. It then executes the memory-reference instructions, which are logical AND, two's complement add, increment-and-skip-if-zero, deposit-and-clear, subroutine call, jump and character output.

Operate-class instructions are not decoded here. The core presents the instruction word, the accumulator and the Link to an external microinstruction unit. It waits for that unit's completion strobe, then takes back the new accumulator, Link and skip decision. A `run` level starts execution from `start_pc`. A `halt` level stops the machine, but only between instructions.

Top module: `acc12_core`

## Requirements
- R1: After a synchronous active-low reset, `running`, `mem_we`, `con_valid` and `opr_start` are 0, and the accumulator (`opr_ac`) and Link (`opr_link`) are 0.
- R2: An instruction word holds the opcode in bits [11:9], the indirect flag in bit [8], the page-select flag in bit [7] and the offset in bits [6:0]. A page-select value of 0 gives the address {5'b0, offset}. A value of 1 gives {upper 5 bits of the instruction's own address, offset}.
- R3: When bit [8] is 1, the word read at the address from R2 is used as the full 12-bit operand address.
- R4: While idle, `run`=1 with `halt`=0 starts execution at `start_pc`. Instructions run in address order, with the PC advanced by one during fetch.
- R5: Opcode 0 (AND) sets the accumulator to the bitwise AND of the accumulator and the operand word.
- R6: Opcode 1 (TAD) adds the operand word to the accumulator modulo 4096 and inverts the Link when the 12-bit addition carries out.
- R7: Opcode 2 (ISZ) writes the operand word plus one back to memory. When the written value is 0, the next instruction is skipped.
- R8: Opcode 3 (DCA) stores the accumulator at the operand address and then clears the accumulator.
- R9: Opcode 4 (JMS) stores the return address (the address after the JMS) at the operand address and continues at operand address + 1. Opcode 5 (JMP) continues at the operand address.
- R10: Opcode 6 (IOT) reads the operand word and raises `con_valid` for exactly one cycle, with `con_char` equal to the word's low 8 bits.
- R11: Opcode 7 raises `opr_start` with the instruction on `opr_ir` and holds it until `opr_done`. On `opr_done`, the accumulator and Link take `opr_ac_in` and `opr_link_in`, and `opr_skip`=1 skips the next instruction.
- R12: `halt`=1 takes effect only when an instruction completes. `running` falls only after `halt` was high, and while `halt` is high, `run` does not start the machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Start request while idle |
| halt | input | 1 | Stop request, honoured between instructions |
| start_pc | input | 12 | First instruction address loaded on start |
| running | output | 1 | Machine is executing |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 12 | Memory read data, valid the cycle after the address |
| con_valid | output | 1 | Console character strobe |
| con_char | output | 8 | Console character |
| opr_start | output | 1 | Operate instruction handed to the microinstruction unit |
| opr_ir | output | 12 | Current instruction word |
| opr_ac | output | 12 | Current accumulator |
| opr_link | output | 1 | Current Link |
| opr_done | input | 1 | Microinstruction unit finished |
| opr_ac_in | input | 12 | New accumulator from the unit |
| opr_link_in | input | 1 | New Link from the unit |
| opr_skip | input | 1 | Skip request from the unit |

## Verification
Two things can meet in one instruction: a stop request, and the write-back or PC redirect of the instruction in flight. This happens with ISZ, whose memory write and possible skip land in its last cycle. A tight ISZ/JMP loop is halted after a chosen number of cycles, and the counter word is then read from memory. It must be stable after the halt, and the machine must stay idle while `halt` is held. Resuming must continue counting from the stored value, which shows that no partial write or skipped increment was left behind. Randomly built AND/TAD programs are compared against a bench model of accumulator and Link.

// File: rtl/acc12_pkg.sv
// Shared opcode and sequencer state definitions for the 12-bit accumulator core.
// Assumes the opcode field is three bits wide and sits at the top of the word.
package acc12_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_TAD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5,
        OP_IOT = 3'd6,
        OP_OPR = 3'd7
    } opcode_e;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_FETCH  = 4'd1,
        ST_LOADIR = 4'd2,
        ST_DECODE = 4'd3,
        ST_INDIR  = 4'd4,
        ST_EXEC   = 4'd5,
        ST_FINISH = 4'd6,
        ST_WRITE  = 4'd7,
        ST_OPER   = 4'd8
    } state_e;

endpackage

// File: rtl/acc12_ea.sv
// Direct operand address former: places the instruction offset on page zero or
// on the instruction's own page. Purely combinational; assumes the page number
// supplied is that of the instruction being loaded (PC before its increment).
module acc12_ea #(
    parameter int WORD_W = 12,
    parameter int OFF_W  = 7
) (
    input  logic [WORD_W-1:0]       instr,
    input  logic [WORD_W-OFF_W-1:0] cur_page,
    output logic [WORD_W-1:0]       ea_direct
);
    localparam int PAGE_W  = WORD_W - OFF_W;
    localparam int SEL_BIT = OFF_W;

    // Choose page zero or the current page for the upper address bits.
    always_comb begin
        if (instr[SEL_BIT])
            ea_direct = {cur_page, instr[OFF_W-1:0]};
        else
            ea_direct = {{PAGE_W{1'b0}}, instr[OFF_W-1:0]};
    end
endmodule

// File: rtl/acc12_alu.sv
// Operand arithmetic for the memory-reference group: AND, two's complement add
// with Link inversion on carry, and the increment used by ISZ. Combinational.
module acc12_alu #(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0] ac,
    input  logic              link,
    input  logic [WORD_W-1:0] opd,
    output logic [WORD_W-1:0] and_res,
    output logic [WORD_W-1:0] add_res,
    output logic              add_link,
    output logic [WORD_W-1:0] inc_res
);
    logic [WORD_W:0] sum_w;

    // Bitwise AND of accumulator and operand.
    always_comb and_res = ac & opd;

    // Wide sum; the carry out of the word toggles the Link.
    always_comb begin
        sum_w    = {1'b0, ac} + {1'b0, opd};
        add_res  = sum_w[WORD_W-1:0];
        add_link = link ^ sum_w[WORD_W];
    end

    // Operand plus one for increment-and-skip.
    always_comb inc_res = opd + WORD_W'(1);
endmodule

// File: rtl/acc12_ctrl.sv
// Instruction sequencer: fetch, decode, optional indirect read, execute, and
// the wait for the operate unit. Halt is sampled only when an instruction ends.
// Assumes the opcode and indirect flag come from the registered instruction.
module acc12_ctrl
    import acc12_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run,
    input  logic    halt,
    input  opcode_e op,
    input  logic    indirect,
    input  logic    opr_done,
    output state_e  state
);
    state_e state_nx;
    state_e boundary;

    // Where to go once an instruction has completed.
    always_comb boundary = halt ? ST_IDLE : ST_FETCH;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (run && !halt) state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_LOADIR;
            ST_LOADIR: state_nx = ST_DECODE;
            ST_DECODE: begin
                if (op == OP_OPR)  state_nx = ST_OPER;
                else if (indirect) state_nx = ST_INDIR;
                else               state_nx = ST_EXEC;
            end
            ST_INDIR:  state_nx = ST_EXEC;
            ST_EXEC: begin
                unique case (op)
                    OP_AND, OP_TAD, OP_ISZ, OP_IOT: state_nx = ST_FINISH;
                    OP_DCA, OP_JMS:                 state_nx = ST_WRITE;
                    default:                        state_nx = boundary;
                endcase
            end
            ST_FINISH: state_nx = (op == OP_ISZ) ? ST_WRITE : boundary;
            ST_WRITE:  state_nx = boundary;
            ST_OPER:   if (opr_done) state_nx = boundary;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    AST_OPR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPER && !opr_done) |=> (state == ST_OPER)); // R11

    AST_INDIR_AFTER_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INDIR) |-> ($past(state) == ST_DECODE)); // R3
endmodule

// File: rtl/acc12_core.sv
// Top of the 12-bit accumulator core. Holds PC, MA, MB, AC, Link and IR, drives
// a synchronous single-port memory (read data one cycle after the address) and
// all writes go out from MB at MA. Operate instructions are handed off through
// the opr_* handshake; the console strobe carries the operand's low byte.
module acc12_core
    import acc12_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int OFF_W  = 7,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              halt,
    input  logic [WORD_W-1:0] start_pc,
    output logic              running,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              con_valid,
    output logic [CHAR_W-1:0] con_char,
    output logic              opr_start,
    output logic [WORD_W-1:0] opr_ir,
    output logic [WORD_W-1:0] opr_ac,
    output logic              opr_link,
    input  logic              opr_done,
    input  logic [WORD_W-1:0] opr_ac_in,
    input  logic              opr_link_in,
    input  logic              opr_skip
);
    localparam int PAGE_W = WORD_W - OFF_W;
    localparam int IND_BIT = OFF_W + 1;

    logic [WORD_W-1:0] pc, ma, mb, ac, ir;
    logic              link;
    state_e            state;
    opcode_e           op;
    logic [WORD_W-1:0] ea_direct, and_res, add_res, inc_res;
    logic              add_link;

    // Opcode taken from the top three bits of the held instruction.
    always_comb op = opcode_e'(ir[WORD_W-1:WORD_W-3]);

    acc12_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .halt     (halt),
        .op       (op),
        .indirect (ir[IND_BIT]),
        .opr_done (opr_done),
        .state    (state)
    );

    acc12_ea #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_ea (
        .instr     (mem_rdata),
        .cur_page  (pc[WORD_W-1:OFF_W]),
        .ea_direct (ea_direct)
    );

    acc12_alu #(.WORD_W(WORD_W)) u_alu (
        .ac       (ac),
        .link     (link),
        .opd      (mem_rdata),
        .and_res  (and_res),
        .add_res  (add_res),
        .add_link (add_link),
        .inc_res  (inc_res)
    );

    // Program counter: start, fetch increment, jumps and skips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            unique case (state)
                ST_IDLE:   if (run && !halt) pc <= start_pc;
                ST_LOADIR: pc <= pc + WORD_W'(1);
                ST_EXEC:   if (op == OP_JMP) pc <= ma;
                ST_WRITE: begin
                    if (op == OP_JMS)                     pc <= ma + WORD_W'(1);
                    else if (op == OP_ISZ && mb == '0)    pc <= pc + WORD_W'(1);
                end
                ST_OPER:   if (opr_done && opr_skip) pc <= pc + WORD_W'(1);
                default: ;
            endcase
        end
    end

    // Instruction register and operand address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir <= '0;
            ma <= '0;
        end else if (state == ST_LOADIR) begin
            ir <= mem_rdata;
            ma <= ea_direct;
        end else if (state == ST_INDIR) begin
            ma <= mem_rdata;
        end
    end

    // Memory buffer: the word to be written back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mb <= '0;
        end else if (state == ST_EXEC && op == OP_DCA) begin
            mb <= ac;
        end else if (state == ST_EXEC && op == OP_JMS) begin
            mb <= pc;
        end else if (state == ST_FINISH && op == OP_ISZ) begin
            mb <= inc_res;
        end
    end

    // Accumulator and Link updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac   <= '0;
            link <= 1'b0;
        end else begin
            unique case (state)
                ST_FINISH: begin
                    if (op == OP_AND) ac <= and_res;
                    if (op == OP_TAD) begin
                        ac   <= add_res;
                        link <= add_link;
                    end
                end
                ST_WRITE: if (op == OP_DCA) ac <= '0;
                ST_OPER: if (opr_done) begin
                    ac   <= opr_ac_in;
                    link <= opr_link_in;
                end
                default: ;
            endcase
        end
    end

    // Memory port, console strobe and operate hand-off.
    always_comb begin
        mem_addr  = (state == ST_FETCH) ? pc : ma;
        mem_we    = (state == ST_WRITE);
        mem_wdata = mb;
        con_valid = (state == ST_FINISH) && (op == OP_IOT);
        con_char  = mem_rdata[CHAR_W-1:0];
        opr_start = (state == ST_OPER);
        opr_ir    = ir;
        opr_ac    = ac;
        opr_link  = link;
        running   = (state != ST_IDLE);
    end

    AST_FETCH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOADIR) |=> (pc == $past(pc) + WORD_W'(1))); // R4

    AST_DEPOSIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && op == OP_DCA) |=> (ac == '0)); // R8

    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && op == OP_JMS) |=> (pc == $past(ma) + WORD_W'(1))); // R9

    AST_CON_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        con_valid |=> !con_valid); // R10

    AST_STOP_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(halt)); // R12

    AST_PAGE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOADIR && !mem_rdata[OFF_W]) |=> (ma[WORD_W-1:OFF_W] == PAGE_W'(0))); // R2
endmodule

// File: tb/acc12_core_test.sv
// Bench for acc12_core: memory model, operate responder, directed programs and
// randomly built AND/TAD programs checked against a bench model.
module acc12_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        halt = 1'b0;
    logic [11:0] start_pc = '0;
    logic        running;
    logic [11:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;
    logic        con_valid;
    logic [7:0]  con_char;
    logic        opr_start, opr_link, opr_done, opr_link_in, opr_skip;
    logic [11:0] opr_ir, opr_ac, opr_ac_in;

    logic [11:0] mem [4096];
    int checks = 0;
    int errors = 0;
    int con_count = 0;
    logic [7:0] con_last = '0;
    int cyc = 0;

    always #5 clk = ~clk;

    acc12_core uut (
        .clk(clk), .rst_n(rst_n), .run(run), .halt(halt), .start_pc(start_pc),
        .running(running), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .con_valid(con_valid),
        .con_char(con_char), .opr_start(opr_start), .opr_ir(opr_ir),
        .opr_ac(opr_ac), .opr_link(opr_link), .opr_done(opr_done),
        .opr_ac_in(opr_ac_in), .opr_link_in(opr_link_in), .opr_skip(opr_skip)
    );

    // Synchronous single-port memory model.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // Operate responder: complements AC and Link, skips when instruction bit 0 is set.
    assign opr_done    = opr_start;
    assign opr_ac_in   = ~opr_ac;
    assign opr_link_in = ~opr_link;
    assign opr_skip    = opr_ir[0];

    // Console monitor.
    always @(posedge clk) begin
        if (con_valid) begin
            con_count <= con_count + 1;
            con_last  <= con_char;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input logic [2:0] op, input logic ind,
                                       input logic cur, input logic [6:0] off);
        return {op, ind, cur, off};
    endfunction

    // Bench model of AND (0) and TAD (1): returns {link, ac}.
    function automatic logic [12:0] model(input logic [2:0] op, input logic [11:0] ac,
                                          input logic lk, input logic [11:0] m);
        logic [12:0] s;
        if (op == 3'd0) return {lk, ac & m};
        s = {1'b0, ac} + {1'b0, m};
        return {lk ^ s[12], s[11:0]};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_stop();
        for (int i = 0; i < 200 && running; i++) @(negedge clk);
    endtask

    task automatic run_prog(input logic [11:0] s, input int n);
        start_pc = s;
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        repeat (n) @(negedge clk);
        halt = 1'b1;
        wait_stop();
        halt = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [11:0] ac_m;
        logic        lk_m;
        logic [12:0] r;
        logic [11:0] c1, c2;
        void'($urandom(32'd1546));
        clear_mem();
        do_reset();

        // R1 reset state
        chk("R1 running", running, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 con_valid", con_valid, 0);
        chk("R1 opr_start", opr_start, 0);
        chk("R1 ac", opr_ac, 0);
        chk("R1 link", opr_link, 0);

        // R3 indirect TAD through page-zero pointer; R4 start address
        mem[12'h005] = 12'h7A3;
        mem[12'h7A3] = 12'h123;
        mem[12'h080] = mk(3'd1, 1'b1, 1'b0, 7'h05);
        mem[12'h081] = mk(3'd3, 1'b0, 1'b0, 7'h10);
        mem[12'h082] = mk(3'd5, 1'b0, 1'b1, 7'h02);
        run_prog(12'h080, 40);
        chk("R3 indirect operand", mem[12'h010], 12'h123);
        chk("R8 ac cleared", opr_ac, 0);

        // R7 ISZ with wrap to zero: skip
        clear_mem(); do_reset();
        mem[12'h020] = 12'hFFF; mem[12'h021] = 12'h111; mem[12'h022] = 12'h222;
        mem[12'h080] = mk(3'd2, 1'b0, 1'b0, 7'h20);
        mem[12'h081] = mk(3'd1, 1'b0, 1'b0, 7'h21);
        mem[12'h082] = mk(3'd1, 1'b0, 1'b0, 7'h22);
        mem[12'h083] = mk(3'd3, 1'b0, 1'b0, 7'h10);
        mem[12'h084] = mk(3'd5, 1'b0, 1'b1, 7'h04);
        run_prog(12'h080, 60);
        chk("R7 isz wrote zero", mem[12'h020], 12'h000);
        chk("R7 isz skipped", mem[12'h010], 12'h222);

        // R7 ISZ non-zero: no skip
        clear_mem(); do_reset();
        mem[12'h020] = 12'h005; mem[12'h021] = 12'h111; mem[12'h022] = 12'h222;
        mem[12'h080] = mk(3'd2, 1'b0, 1'b0, 7'h20);
        mem[12'h081] = mk(3'd1, 1'b0, 1'b0, 7'h21);
        mem[12'h082] = mk(3'd1, 1'b0, 1'b0, 7'h22);
        mem[12'h083] = mk(3'd3, 1'b0, 1'b0, 7'h10);
        mem[12'h084] = mk(3'd5, 1'b0, 1'b1, 7'h04);
        run_prog(12'h080, 60);
        chk("R7 isz incremented", mem[12'h020], 12'h006);
        chk("R7 isz no skip", mem[12'h010], 12'h333);

        // R9 JMS/JMP, R2 current page on page 2, R10 console
        clear_mem(); do_reset();
        mem[12'h160] = 12'h5A5;
        mem[12'h161] = 12'hA4B;
        mem[12'h100] = mk(3'd4, 1'b0, 1'b1, 7'h40);
        mem[12'h101] = mk(3'd3, 1'b0, 1'b0, 7'h10);
        mem[12'h102] = mk(3'd6, 1'b0, 1'b1, 7'h61);
        mem[12'h103] = mk(3'd5, 1'b0, 1'b1, 7'h03);
        mem[12'h141] = mk(3'd1, 1'b0, 1'b1, 7'h60);
        mem[12'h142] = mk(3'd5, 1'b1, 1'b1, 7'h40);
        con_count = 0;
        run_prog(12'h100, 80);
        chk("R9 jms return word", mem[12'h140], 12'h101);
        chk("R2 current-page operand via R9 return", mem[12'h010], 12'h5A5);
        chk("R10 one strobe", con_count, 1);
        chk("R10 char low byte", con_last, 8'h4B);

        // R11 operate hand-off with skip
        clear_mem(); do_reset();
        mem[12'h021] = 12'h0F0; mem[12'h022] = 12'h003;
        mem[12'h080] = mk(3'd1, 1'b0, 1'b0, 7'h21);
        mem[12'h081] = 12'hE01;
        mem[12'h082] = mk(3'd1, 1'b0, 1'b0, 7'h22);
        mem[12'h083] = mk(3'd3, 1'b0, 1'b0, 7'h10);
        mem[12'h084] = mk(3'd5, 1'b0, 1'b1, 7'h04);
        run_prog(12'h080, 60);
        chk("R11 opr ac with skip", mem[12'h010], 12'hF0F);
        chk("R11 opr link", opr_link, 1);

        // R11 operate without skip
        clear_mem(); do_reset();
        mem[12'h021] = 12'h0F0; mem[12'h022] = 12'h003;
        mem[12'h080] = mk(3'd1, 1'b0, 1'b0, 7'h21);
        mem[12'h081] = 12'hE00;
        mem[12'h082] = mk(3'd1, 1'b0, 1'b0, 7'h22);
        mem[12'h083] = mk(3'd3, 1'b0, 1'b0, 7'h10);
        mem[12'h084] = mk(3'd5, 1'b0, 1'b1, 7'h04);
        run_prog(12'h080, 60);
        chk("R11 opr no skip", mem[12'h010], 12'hF12);

        // R6 directed carry: link inverts
        clear_mem(); do_reset();
        mem[12'h021] = 12'hFFF; mem[12'h022] = 12'h002;
        mem[12'h080] = mk(3'd1, 1'b0, 1'b0, 7'h21);
        mem[12'h081] = mk(3'd1, 1'b0, 1'b0, 7'h22);
        mem[12'h082] = mk(3'd3, 1'b0, 1'b0, 7'h10);
        mem[12'h083] = mk(3'd5, 1'b0, 1'b1, 7'h03);
        run_prog(12'h080, 50);
        chk("R6 carry sum", mem[12'h010], 12'h001);
        chk("R6 carry link", opr_link, 1);

        // R5/R6/R2 random AND/TAD programs
        for (int t = 0; t < 12; t++) begin
            clear_mem(); do_reset();
            for (int a = 12'h020; a < 12'h040; a++) mem[a] = 12'($urandom);
            for (int a = 12'h0E0; a < 12'h100; a++) mem[a] = 12'($urandom);
            ac_m = '0; lk_m = 1'b0;
            for (int k = 0; k < 10; k++) begin
                logic [2:0] op;
                logic cur;
                logic [6:0] off;
                op  = 3'($urandom % 2);
                cur = 1'($urandom);
                off = cur ? 7'(7'h60 + ($urandom % 32)) : 7'(7'h20 + ($urandom % 32));
                mem[12'h080 + k] = mk(op, 1'b0, cur, off);
                r = model(op, ac_m, lk_m, mem[cur ? {5'd1, off} : {5'd0, off}]);
                lk_m = r[12]; ac_m = r[11:0];
            end
            mem[12'h08A] = mk(3'd3, 1'b0, 1'b0, 7'h10);
            mem[12'h08B] = mk(3'd5, 1'b0, 1'b1, 7'h0B);
            run_prog(12'h080, 120);
            chk("R5 R6 random ac", mem[12'h010], ac_m);
            chk("R6 random link", opr_link, lk_m);
        end

        // R12 halt on boundary with ISZ/JMP loop
        clear_mem(); do_reset();
        mem[12'h080] = mk(3'd2, 1'b0, 1'b0, 7'h20);
        mem[12'h081] = mk(3'd5, 1'b0, 1'b1, 7'h00);
        run_prog(12'h080, 100);
        c1 = mem[12'h020];
        chk("R12 stopped", running, 0);
        chk("R12 count in range", (c1 >= 12'd5 && c1 <= 12'd15), 1);
        repeat (20) @(negedge clk);
        chk("R12 no change after halt", mem[12'h020], c1);
        halt = 1'b1; run = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 halt blocks run", running, 0);
        run = 1'b0; halt = 1'b0;
        @(negedge clk);
        run_prog(12'h080, 50);
        c2 = mem[12'h020];
        chk("R12 resumes counting", (c2 > c1), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule